// File: doc/BRIEF.md
# Memory-Request to AXI4-Lite Bridge

This block lets a client that speaks a plain request/grant memory protocol reach an AXI4-Lite subordinate. The client raises a request with an address, a write flag, write data and byte strobes. The bridge grants the request when it can take it. Each granted request becomes either a read on the AR/R channels or a write on the AW/W/B channels. Several requests may be open at once, up to a parameterised limit. The latency of each one is set by the downstream system and is never assumed to be a single cycle.

A small first-in first-out tracker records whether each granted request was a read or a write. The response side uses the oldest entry to decide which completion channel it will accept. This merges read and write completions into one response stream that keeps the order in which requests were granted. Every granted request ends with exactly one response pulse, which carries the read data and an error flag. A fixed protection value comes from a parameter. The cache attributes of each transaction are taken from two input ports at the moment of the grant.

Top module: `memlite_bridge`

## Requirements
- R1: A request is taken in a cycle where `mreq_valid` and `mreq_grant` are both high, and `mreq_grant` is never high while `mreq_valid` is low. `mreq_write` = 0 selects a read and `mreq_write` = 1 selects a write.
- R2: A granted read produces one AR transfer. Its address is `mreq_addr` zero-extended to the AXI width, `m_arprot` equals `ACCESS_PROT`, and `m_arcache` equals `ar_cache_in` as sampled at the grant. `m_arvalid` is high in the cycle after the grant.
- R3: A granted write produces one AW transfer and one W transfer. The AW transfer carries the zero-extended address, `ACCESS_PROT` and `aw_cache_in` as sampled at the grant. The W transfer carries `mreq_wdata` and `mreq_strb`, where strobe bit i, active high, enables data byte i. AW and W may complete in different cycles.
- R4: Once `m_arvalid`, `m_awvalid` or `m_wvalid` is high, that signal and its payload stay unchanged until the matching ready is seen high at a clock edge.
- R5: No more than `MAX_OUTSTANDING` requests are granted and not yet answered. While that many are open, grant stays low.
- R6: A request is not granted while the channel it needs still holds an earlier transfer whose ready is low. A write needs both the AW and the W channel to be free. A read is not held back by stalled write channels, and a write is not held back by a stalled read channel.
- R7: `m_rready` is high only when the oldest open request is a read, and `m_bready` is high only when it is a write. Both are low when nothing is open, and the two are never high together.
- R8: Every granted request gives exactly one single-cycle `mrsp_valid` pulse, in grant order. For a read, `mrsp_rdata` equals `m_rdata` in the cycle of the R handshake.
- R9: `mrsp_err` is bit 1 of the completing response code. It is 1 for 2'b10 and 2'b11, and 0 for 2'b00 and 2'b01.
- R10: While `rst_n` is low at a clock edge, the bridge clears all valid outputs toward AXI, both ready outputs and `mrsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mreq_valid | input | 1 | Client request present |
| mreq_addr | input | MEM_ADDR_W | Client byte address |
| mreq_write | input | 1 | 1 write, 0 read |
| mreq_wdata | input | DATA_W | Write data |
| mreq_strb | input | DATA_W/8 | Byte enables, active high |
| mreq_grant | output | 1 | Request taken this cycle |
| mrsp_valid | output | 1 | One-cycle response pulse |
| mrsp_rdata | output | DATA_W | Read data of the response |
| mrsp_err | output | 1 | Error flag of the response |
| aw_cache_in | input | 4 | Cache attributes for writes |
| ar_cache_in | input | 4 | Cache attributes for reads |
| m_awaddr | output | AXI_ADDR_W | Write address |
| m_awprot | output | 3 | Write protection |
| m_awcache | output | 4 | Write cache attributes |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | AXI_ADDR_W | Read address |
| m_arprot | output | 3 | Read protection |
| m_arcache | output | 4 | Read cache attributes |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
A corrupted order tracker shows up at the ports in the very next cycle. `m_rready` or `m_bready` then points at the wrong channel compared with the oldest open request, or a response pulse carries the data or error of another transaction. A wrong occupancy count is seen within a few cycles. It appears either as grants beyond the outstanding limit while completions are held back, or as a grant that never comes. A lost or clobbered channel slot appears at the next AR, AW or W handshake as a payload mismatch or a missing transfer. It also appears when the slave still has requests to answer after the run has drained.

// File: rtl/memlite_pkg.sv
// Shared types and helpers for the memory-request to AXI4-Lite bridge.
package memlite_pkg;

    // Kind of a granted request, kept in the order tracker.
    typedef enum logic {
        KIND_READ  = 1'b0,
        KIND_WRITE = 1'b1
    } req_kind_e;

    localparam int unsigned AXI_RESP_W = 2;
    localparam int unsigned PROT_W     = 3;
    localparam int unsigned CACHE_W    = 4;

    // A response code flags an error when its upper bit is set.
    function automatic logic resp_is_error(input logic [AXI_RESP_W-1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/mlb_order_fifo.sv
// Order tracker: a circular FIFO of request kinds, one entry per open request.
// Assumes the caller never pushes when full and never pops when empty.
module mlb_order_fifo
    import memlite_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  req_kind_e push_kind,
    input  logic      pop,
    output req_kind_e head_kind,
    output logic      empty,
    output logic      full
);
    localparam int unsigned PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST     = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    req_kind_e        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] level;

    // Advance a pointer and wrap it at the last slot.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Store the kind of a newly granted request.
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_kind;
        end
    end

    // Update the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign empty     = (level == '0);
    assign full      = (level == FULL_CNT);
    assign head_kind = slots[rd_ptr];

    // R5: never written beyond its depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_CNT);
    // R8: a completion always has an open request to retire
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/mlb_chan_slot.sv
// One-entry holding stage for an AXI address or data channel.
// The payload is loaded only when can_load is high, and it is held until ready.
module mlb_chan_slot #(
    parameter int unsigned PAYLOAD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [PAYLOAD_W-1:0] load_data,
    output logic                 valid,
    input  logic                 ready,
    output logic [PAYLOAD_W-1:0] data,
    output logic                 can_load
);
    // The slot is free when empty or when it drains in this cycle.
    assign can_load = !valid || ready;

    // Track whether a transfer is being offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // Capture the payload of a new transfer.
    always_ff @(posedge clk) begin
        if (load) begin
            data <= load_data;
        end
    end

    // R4: an offered transfer stays put until it is taken
    a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && $stable(data));
    // R6: the grant logic never loads over a waiting transfer
    a_r6_no_clobber: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> can_load);

endmodule

// File: rtl/mlb_resp_merge.sv
// Response merge: opens only the completion channel that matches the oldest
// open request and turns the accepted completion into one response pulse.
module mlb_resp_merge
    import memlite_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  order_empty,
    input  req_kind_e             head_kind,
    input  logic                  r_valid,
    input  logic [AXI_RESP_W-1:0] r_resp,
    input  logic [DATA_W-1:0]     r_data,
    output logic                  r_ready,
    input  logic                  b_valid,
    input  logic [AXI_RESP_W-1:0] b_resp,
    output logic                  b_ready,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  retire
);
    logic r_fire;
    logic b_fire;

    // Open only the channel that the oldest open request waits on.
    always_comb begin
        r_ready = !order_empty && (head_kind == KIND_READ);
        b_ready = !order_empty && (head_kind == KIND_WRITE);
    end

    assign r_fire = r_valid && r_ready;
    assign b_fire = b_valid && b_ready;

    // Build the response from whichever completion was accepted.
    always_comb begin
        rsp_valid = r_fire || b_fire;
        rsp_rdata = r_data;
        if (r_fire) begin
            rsp_err = resp_is_error(r_resp);
        end else if (b_fire) begin
            rsp_err = resp_is_error(b_resp);
        end else begin
            rsp_err = 1'b0;
        end
    end

    assign retire = rsp_valid;

    // R7: the head of the order does not move without a completion
    a_r7_head_waits: assert property (@(posedge clk) disable iff (!rst_n)
        r_ready && !r_valid |=> r_ready);

endmodule

// File: rtl/memlite_bridge.sv
// Memory-request to AXI4-Lite bridge (top).
// Grants client requests into one-entry AXI channel slots, records each
// request's kind in order, and merges the B and R completions in grant order.
// Assumes the AXI subordinate answers each channel in the order it was issued.
module memlite_bridge
    import memlite_pkg::*;
#(
    parameter int unsigned       MEM_ADDR_W      = 16,
    parameter int unsigned       AXI_ADDR_W      = 32,
    parameter int unsigned       DATA_W          = 32,
    parameter int unsigned       MAX_OUTSTANDING = 4,
    parameter logic [PROT_W-1:0] ACCESS_PROT     = 3'b010
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mreq_valid,
    input  logic [MEM_ADDR_W-1:0] mreq_addr,
    input  logic                  mreq_write,
    input  logic [DATA_W-1:0]     mreq_wdata,
    input  logic [DATA_W/8-1:0]   mreq_strb,
    output logic                  mreq_grant,
    output logic                  mrsp_valid,
    output logic [DATA_W-1:0]     mrsp_rdata,
    output logic                  mrsp_err,
    input  logic [CACHE_W-1:0]    aw_cache_in,
    input  logic [CACHE_W-1:0]    ar_cache_in,
    output logic [AXI_ADDR_W-1:0] m_awaddr,
    output logic [PROT_W-1:0]     m_awprot,
    output logic [CACHE_W-1:0]    m_awcache,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W/8-1:0]   m_wstrb,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    input  logic [AXI_RESP_W-1:0] m_bresp,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    output logic [AXI_ADDR_W-1:0] m_araddr,
    output logic [PROT_W-1:0]     m_arprot,
    output logic [CACHE_W-1:0]    m_arcache,
    output logic                  m_arvalid,
    input  logic                  m_arready,
    input  logic [DATA_W-1:0]     m_rdata,
    input  logic [AXI_RESP_W-1:0] m_rresp,
    input  logic                  m_rvalid,
    output logic                  m_rready
);
    localparam int unsigned STRB_W = DATA_W / 8;
    localparam int unsigned ADDR_PAYLOAD_W = CACHE_W + AXI_ADDR_W;
    localparam int unsigned DATA_PAYLOAD_W = STRB_W + DATA_W;

    logic [AXI_ADDR_W-1:0] axi_addr;
    logic aw_can, w_can, ar_can;
    logic chan_free;
    logic order_full, order_empty;
    logic accept, retire;
    req_kind_e head_kind;
    logic [ADDR_PAYLOAD_W-1:0] aw_payload, ar_payload;
    logic [DATA_PAYLOAD_W-1:0] w_payload;

    // Fit the client byte address to the AXI address width.
    generate
        if (AXI_ADDR_W > MEM_ADDR_W) begin : g_widen
            assign axi_addr = {{(AXI_ADDR_W - MEM_ADDR_W){1'b0}}, mreq_addr};
        end else begin : g_narrow
            assign axi_addr = mreq_addr[AXI_ADDR_W-1:0];
        end
    endgenerate

    // Grant only when the order tracker and every needed channel can take it.
    always_comb begin
        chan_free  = mreq_write ? (aw_can && w_can) : ar_can;
        mreq_grant = mreq_valid && !order_full && chan_free;
    end

    assign accept = mreq_grant;

    mlb_order_fifo #(
        .DEPTH(MAX_OUTSTANDING)
    ) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .push_kind(mreq_write ? KIND_WRITE : KIND_READ),
        .pop      (retire),
        .head_kind(head_kind),
        .empty    (order_empty),
        .full     (order_full)
    );

    mlb_chan_slot #(
        .PAYLOAD_W(ADDR_PAYLOAD_W)
    ) u_aw (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && mreq_write),
        .load_data({aw_cache_in, axi_addr}),
        .valid    (m_awvalid),
        .ready    (m_awready),
        .data     (aw_payload),
        .can_load (aw_can)
    );

    mlb_chan_slot #(
        .PAYLOAD_W(DATA_PAYLOAD_W)
    ) u_w (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && mreq_write),
        .load_data({mreq_strb, mreq_wdata}),
        .valid    (m_wvalid),
        .ready    (m_wready),
        .data     (w_payload),
        .can_load (w_can)
    );

    mlb_chan_slot #(
        .PAYLOAD_W(ADDR_PAYLOAD_W)
    ) u_ar (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !mreq_write),
        .load_data({ar_cache_in, axi_addr}),
        .valid    (m_arvalid),
        .ready    (m_arready),
        .data     (ar_payload),
        .can_load (ar_can)
    );

    // Split the slot payloads onto the AXI fields.
    always_comb begin
        {m_awcache, m_awaddr} = aw_payload;
        {m_arcache, m_araddr} = ar_payload;
        {m_wstrb, m_wdata}    = w_payload;
        m_awprot              = ACCESS_PROT;
        m_arprot              = ACCESS_PROT;
    end

    mlb_resp_merge #(
        .DATA_W(DATA_W)
    ) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .order_empty(order_empty),
        .head_kind  (head_kind),
        .r_valid    (m_rvalid),
        .r_resp     (m_rresp),
        .r_data     (m_rdata),
        .r_ready    (m_rready),
        .b_valid    (m_bvalid),
        .b_resp     (m_bresp),
        .b_ready    (m_bready),
        .rsp_valid  (mrsp_valid),
        .rsp_err    (mrsp_err),
        .rsp_rdata  (mrsp_rdata),
        .retire     (retire)
    );

    // R2: a granted read is offered on AR in the next cycle
    a_r2_read_issued: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !mreq_write |=> m_arvalid && (m_araddr == $past(axi_addr))
                                  && (m_arcache == $past(ar_cache_in)));
    // R3: a granted write is offered on both AW and W in the next cycle
    a_r3_write_issued: assert property (@(posedge clk) disable iff (!rst_n)
        accept && mreq_write |=> m_awvalid && m_wvalid
                                 && (m_wdata == $past(mreq_wdata))
                                 && (m_wstrb == $past(mreq_strb)));

endmodule

// File: tb/sim_memlite_bridge.sv
module sim_memlite_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int MAW  = 16;
    localparam int AAW  = 32;
    localparam int DW   = 32;
    localparam int SW   = DW / 8;
    localparam int MAXO = 4;
    localparam logic [2:0] PROT = 3'b010;

    logic clk = 1'b0;
    logic rst_n;
    logic mreq_valid, mreq_write, mreq_grant;
    logic [MAW-1:0] mreq_addr;
    logic [DW-1:0] mreq_wdata, mrsp_rdata;
    logic [SW-1:0] mreq_strb;
    logic mrsp_valid, mrsp_err;
    logic [3:0] aw_cache_in, ar_cache_in, m_awcache, m_arcache;
    logic [AAW-1:0] m_awaddr, m_araddr;
    logic [2:0] m_awprot, m_arprot;
    logic m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
    logic m_arvalid, m_arready, m_rvalid, m_rready;
    logic [DW-1:0] m_wdata, m_rdata;
    logic [SW-1:0] m_wstrb;
    logic [1:0] m_bresp, m_rresp;

    memlite_bridge #(
        .MEM_ADDR_W(MAW), .AXI_ADDR_W(AAW), .DATA_W(DW),
        .MAX_OUTSTANDING(MAXO), .ACCESS_PROT(PROT)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .mreq_valid(mreq_valid), .mreq_addr(mreq_addr), .mreq_write(mreq_write),
        .mreq_wdata(mreq_wdata), .mreq_strb(mreq_strb), .mreq_grant(mreq_grant),
        .mrsp_valid(mrsp_valid), .mrsp_rdata(mrsp_rdata), .mrsp_err(mrsp_err),
        .aw_cache_in(aw_cache_in), .ar_cache_in(ar_cache_in),
        .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awcache(m_awcache),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arcache(m_arcache),
        .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int acc_total = 0;
    int rsp_total = 0;
    int smode = 0;
    bit hold_resp = 0, ar_stall = 0, aw_stall = 0, w_stall = 0;

    logic [16:0] exp_rsp [$];   // {write, addr}
    logic [19:0] exp_ar [$];    // {cache, addr}
    logic [19:0] exp_aw [$];
    logic [35:0] exp_w [$];     // {strb, data}
    logic [15:0] sl_r [$];
    logic [15:0] sl_aw [$];
    logic [15:0] sl_b [$];
    int sl_wn = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] read_word(input logic [15:0] a);
        return ({16'h0, a} * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
    endfunction

    function automatic logic [1:0] resp_code(input logic [15:0] a, input bit wr);
        return a[5:4] ^ {1'b0, wr};
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired (R8 progress) actual=0 expected=1");
        finish_run();
    end

    // Client-side monitor: grant legality, ordering of readies, responses
    initial begin
        logic [16:0] h;
        logic [1:0] rc;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (mreq_grant) check(mreq_valid, "R1", "grant without request", 0, 1);
                if (exp_rsp.size() == 0)
                    check(!m_rready && !m_bready, "R7", "ready with nothing open",
                          {m_rready, m_bready}, 0);
                else
                    check(m_rready == !exp_rsp[0][16] && m_bready == exp_rsp[0][16],
                          "R7", "ready vs oldest kind", {m_rready, m_bready},
                          {!exp_rsp[0][16], exp_rsp[0][16]});
                if (mrsp_valid) begin
                    if (exp_rsp.size() == 0) begin
                        check(0, "R8", "response with nothing open", 1, 0);
                    end else begin
                        h = exp_rsp.pop_front();
                        rsp_total++;
                        rc = resp_code(h[15:0], h[16]);
                        check(mrsp_err == rc[1], "R9", "error flag", mrsp_err, rc[1]);
                        if (!h[16])
                            check(mrsp_rdata == read_word(h[15:0]), "R8", "read data",
                                  mrsp_rdata, read_word(h[15:0]));
                    end
                end
                if (mreq_valid && mreq_grant) begin
                    acc_total++;
                    exp_rsp.push_back({mreq_write, mreq_addr});
                    if (mreq_write) begin
                        exp_aw.push_back({aw_cache_in, mreq_addr});
                        exp_w.push_back({mreq_strb, mreq_wdata});
                    end else begin
                        exp_ar.push_back({ar_cache_in, mreq_addr});
                    end
                    check(exp_rsp.size() <= MAXO, "R5", "open requests", exp_rsp.size(), MAXO);
                end
            end
        end
    end

    // AXI subordinate model
    initial begin
        bit r_done, b_done, ga, gaw, gw, rg, bg;
        bit ar_pend, aw_pend, w_pend;
        logic [31:0] ar_hold, aw_hold;
        logic [35:0] w_hold;
        logic [19:0] e;
        logic [35:0] ew;
        int cyc;
        cyc = 0; ar_pend = 0; aw_pend = 0; w_pend = 0;
        ar_hold = '0; aw_hold = '0; w_hold = '0;
        m_arready = 0; m_awready = 0; m_wready = 0; m_rvalid = 0; m_bvalid = 0;
        m_rdata = '0; m_rresp = '0; m_bresp = '0;
        forever begin
            @(negedge clk);
            r_done = 0;
            b_done = 0;
            if (rst_n) begin
                if (ar_pend) check(m_arvalid && m_araddr == ar_hold, "R4", "AR held",
                                   m_araddr, ar_hold);
                if (aw_pend) check(m_awvalid && m_awaddr == aw_hold, "R4", "AW held",
                                   m_awaddr, aw_hold);
                if (w_pend) check(m_wvalid && {m_wstrb, m_wdata} == w_hold, "R4", "W held",
                                  m_wdata, w_hold[31:0]);
                if (m_arvalid && m_arready) begin
                    if (exp_ar.size() == 0) begin
                        check(0, "R2", "unexpected AR", 1, 0);
                    end else begin
                        e = exp_ar.pop_front();
                        check(m_araddr == {16'h0, e[15:0]}, "R2", "araddr", m_araddr, e[15:0]);
                        check(m_arcache == e[19:16], "R2", "arcache", m_arcache, e[19:16]);
                        check(m_arprot == PROT, "R2", "arprot", m_arprot, PROT);
                    end
                    sl_r.push_back(m_araddr[15:0]);
                end
                if (m_awvalid && m_awready) begin
                    if (exp_aw.size() == 0) begin
                        check(0, "R3", "unexpected AW", 1, 0);
                    end else begin
                        e = exp_aw.pop_front();
                        check(m_awaddr == {16'h0, e[15:0]}, "R3", "awaddr", m_awaddr, e[15:0]);
                        check(m_awcache == e[19:16], "R3", "awcache", m_awcache, e[19:16]);
                        check(m_awprot == PROT, "R3", "awprot", m_awprot, PROT);
                    end
                    sl_aw.push_back(m_awaddr[15:0]);
                end
                if (m_wvalid && m_wready) begin
                    if (exp_w.size() == 0) begin
                        check(0, "R3", "unexpected W", 1, 0);
                    end else begin
                        ew = exp_w.pop_front();
                        check({m_wstrb, m_wdata} == ew, "R3", "wdata/wstrb",
                              {m_wstrb, m_wdata}, ew);
                    end
                    sl_wn++;
                end
                ar_pend = m_arvalid && !m_arready; ar_hold = m_araddr;
                aw_pend = m_awvalid && !m_awready; aw_hold = m_awaddr;
                w_pend  = m_wvalid && !m_wready;   w_hold  = {m_wstrb, m_wdata};
                r_done = m_rvalid && m_rready;
                b_done = m_bvalid && m_bready;
            end else begin
                ar_pend = 0; aw_pend = 0; w_pend = 0;
            end
            @(posedge clk);
            #1;
            if (r_done) void'(sl_r.pop_front());
            if (b_done) void'(sl_b.pop_front());
            while (sl_aw.size() > 0 && sl_wn > 0) begin
                sl_b.push_back(sl_aw.pop_front());
                sl_wn--;
            end
            cyc++;
            case (smode)
                0: begin ga = 1; gaw = 1; gw = 1; rg = 1; bg = 1; end
                1: begin ga = cyc[0]; gaw = cyc[1]; gw = !cyc[0];
                         rg = (cyc % 3 == 0); bg = (cyc % 5 != 0); end
                2: begin ga = (cyc % 4 == 0); gaw = (cyc % 3 == 1); gw = (cyc % 5 == 2);
                         rg = 1; bg = 1; end
                default: begin ga = 1; gaw = 1; gw = 1; rg = (cyc % 7 < 2); bg = cyc[0]; end
            endcase
            m_arready = ga && !ar_stall;
            m_awready = gaw && !aw_stall;
            m_wready  = gw && !w_stall;
            if (!(m_rvalid && !r_done)) begin
                m_rvalid = (sl_r.size() > 0) && rg && !hold_resp;
                if (sl_r.size() > 0) begin
                    m_rdata = read_word(sl_r[0]);
                    m_rresp = resp_code(sl_r[0], 1'b0);
                end
            end
            if (!(m_bvalid && !b_done)) begin
                m_bvalid = (sl_b.size() > 0) && bg && !hold_resp;
                if (sl_b.size() > 0) m_bresp = resp_code(sl_b[0], 1'b1);
            end
        end
    end

    task automatic issue(input bit wr, input logic [15:0] a, input logic [31:0] d,
                         input logic [3:0] s, input logic [3:0] c);
        mreq_valid = 1; mreq_write = wr; mreq_addr = a; mreq_wdata = d; mreq_strb = s;
        aw_cache_in = c; ar_cache_in = ~c;
        while (1) begin
            @(negedge clk);
            if (mreq_grant) break;
            @(posedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        mreq_valid = 0;
    endtask

    task automatic drain();
        while (exp_rsp.size() != 0) @(posedge clk);
        #1;
    endtask

    // Stimulus
    initial begin
        int base;
        rst_n = 0; mreq_valid = 0; mreq_write = 0; mreq_addr = '0; mreq_wdata = '0;
        mreq_strb = '0; aw_cache_in = '0; ar_cache_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!m_arvalid && !m_awvalid && !m_wvalid, "R10", "AXI valids in reset",
              {m_arvalid, m_awvalid, m_wvalid}, 0);
        check(!m_rready && !m_bready, "R10", "readies in reset", {m_rready, m_bready}, 0);
        check(!mrsp_valid, "R10", "response in reset", mrsp_valid, 0);
        @(posedge clk);
        #1;
        rst_n = 1;

        // Sweep over subordinate timing modes and request mixes
        for (int m = 0; m < 4; m++) begin
            smode = m;
            for (int n = 0; n < 48; n++) begin
                issue(((n * 7 + m) >> 1) & 1, 16'((n * 20) + m * 4096),
                      (n * 32'h0101_0101) ^ m, 4'(n), 4'(n ^ m));
                if (n % 3 == 0) begin
                    @(posedge clk);
                    #1;
                end
            end
            drain();
            check(exp_ar.size() == 0 && exp_aw.size() == 0 && exp_w.size() == 0, "R3",
                  "all channel transfers issued", exp_ar.size() + exp_aw.size() + exp_w.size(), 0);
        end
        check(rsp_total == acc_total, "R8", "one response per request", rsp_total, acc_total);

        // R5: outstanding limit with completions held back
        smode = 0; hold_resp = 1; base = acc_total;
        mreq_valid = 1; mreq_write = 0; mreq_addr = 16'h0400; ar_cache_in = 4'h3;
        repeat (12) @(negedge clk);
        check(acc_total - base == MAXO, "R5", "grants at limit", acc_total - base, MAXO);
        check(!mreq_grant, "R5", "grant while full", mreq_grant, 0);
        @(posedge clk);
        #1;
        mreq_valid = 0; hold_resp = 0;
        drain();
        check(rsp_total == acc_total, "R8", "responses after release", rsp_total, acc_total);

        // R6: stalled AR blocks reads only
        ar_stall = 1; base = acc_total;
        mreq_valid = 1; mreq_write = 0; mreq_addr = 16'h0810;
        repeat (8) @(negedge clk);
        check(acc_total - base == 1, "R6", "reads taken with AR stalled", acc_total - base, 1);
        @(posedge clk);
        #1;
        mreq_write = 1; mreq_wdata = 32'hCAFE_0001; mreq_strb = 4'hF;
        @(negedge clk);
        check(mreq_grant, "R6", "write not blocked by AR", mreq_grant, 1);
        @(posedge clk);
        #1;
        mreq_valid = 0; ar_stall = 0;
        drain();

        // R6: stalled W blocks writes, then stalled AW blocks writes
        w_stall = 1; base = acc_total;
        mreq_valid = 1; mreq_write = 1; mreq_addr = 16'h0920;
        repeat (8) @(negedge clk);
        check(acc_total - base == 1, "R6", "writes taken with W stalled", acc_total - base, 1);
        check(!mreq_grant, "R6", "grant with W full", mreq_grant, 0);
        @(posedge clk);
        #1;
        w_stall = 0; mreq_valid = 0;
        drain();
        aw_stall = 1; base = acc_total;
        mreq_valid = 1; mreq_write = 1; mreq_addr = 16'h0A30;
        repeat (8) @(negedge clk);
        check(acc_total - base == 1, "R6", "writes taken with AW stalled", acc_total - base, 1);
        check(!mreq_grant, "R6", "grant with AW full", mreq_grant, 0);
        @(posedge clk);
        #1;
        mreq_write = 0; mreq_addr = 16'h0A40;
        @(negedge clk);
        check(mreq_grant, "R6", "read not blocked by AW", mreq_grant, 1);
        @(posedge clk);
        #1;
        mreq_valid = 0; aw_stall = 0;
        drain();
        check(rsp_total == acc_total, "R8", "final response count", rsp_total, acc_total);
        finish_run();
    end

endmodule